// File: doc/BRIEF.md
# Register with Local Logic Unit

This block is a general-purpose register with a built-in logic unit. It holds a primary latch (A) and a second operand latch (B). Common loop-counter and bit-manipulation operations run inside the register itself, so the main arithmetic unit is left free for add, subtract, multiply and divide. An operation only needs A, B and a command word, so it can overlap with instruction fetch elsewhere in the processor.

Data enters in one of two ways:
- A load writes A alone.
- A transfer writes the same word into A and B together.

A command selects one of twelve local operations: increment, decrement, bit set, bit clear, bit test, one-position shift, one-position rotate, zero, invert, and AND, OR or XOR of A with B. The result is written back into A, or sent out once on the register-bus port for another register to take. Zero, negative and carry flags are kept for a global flags register to collect.

Top module: `reg_local_unit`

## Requirements
- R1: After a synchronous active-high reset, A, B, the three flags and `rbus_valid` are all 0.
- R2: A load (`ld_en`) writes `ld_data` into A on the next rising edge. B and the flags are not changed.
- R3: A transfer (`xfer_en`) writes `xfer_data` into both A and B on the next rising edge. When `ld_en` and `xfer_en` are both high, the transfer wins.
- R4: Code 1 increments A and code 2 decrements A. After code 1, carry is the carry-out (set when A was all ones). After code 2, carry is the borrow (set when A was 0).
- R5: Code 3 sets and code 4 clears bit `op_arg` of A. `op_arg` is a 4-bit index, where 0 is the least significant bit.
- R6: Code 5 tests bit `op_arg` of A. Zero becomes 1 when that bit is 0 and 0 when it is 1. A, negative and carry keep their values.
- R7: Code 6 shifts A by one place, left when `op_dir` is 1 and right when it is 0. The vacated bit is filled with 0, and carry takes the bit shifted out.
- R8: Code 7 rotates A by one place in the direction given by `op_dir`. The bit leaving one end enters the other end and is also copied into carry.
- R9: Code 8 clears A and code 9 inverts A. Codes 10, 11 and 12 replace A with A AND B, A OR B and A XOR B. None of these five operations changes carry.
- R10: Every operation that produces a result (codes 1–4 and 6–12) sets zero when the result is 0 and sets negative to bit 15 of the result.
- R11: With `op_to_bus` high, the result appears on `rbus_data` with `rbus_valid` high for exactly one cycle after the edge. A is left unchanged and the flags are still updated.
- R12: An operation presented while `ld_en` or `xfer_en` is high is ignored. It changes no flag and produces no bus output.
- R13: Codes 0, 13, 14 and 15 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load A from `ld_data` |
| ld_data | input | 16 | Load value |
| xfer_en | input | 1 | Load A and B from `xfer_data` |
| xfer_data | input | 16 | Transfer value |
| op_valid | input | 1 | Operation command present |
| op_code | input | 4 | Operation select (see requirements) |
| op_arg | input | 4 | Bit index for set, clear and test |
| op_dir | input | 1 | Shift or rotate direction, 1 = left |
| op_to_bus | input | 1 | Send the result to the bus instead of A |
| a_out | output | 16 | Current contents of A |
| rbus_valid | output | 1 | Bus result present this cycle |
| rbus_data | output | 16 | Bus result, 0 when not valid |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry or borrow flag |

## Verification
The bench builds the register at its default width of 16, which gives a 4-bit bit index. Bit-index boundaries are therefore reachable: bit 0, bit 3 and bit 15. The carry edges from all-ones and all-zero are reached, as are shifted-out and rotated bits at both ends and a negative flag driven by the top bit. B is only visible through logic results, so every claim about B is checked by following a load or transfer with an AND, OR or XOR. The collision cases are also driven: load with transfer, load with an operation, and transfer with an operation.

// File: rtl/lrl_pkg.sv
package lrl_pkg;

    localparam int OPW = 4;

    typedef enum logic [OPW-1:0] {
        OP_NOP  = 4'd0,
        OP_INC  = 4'd1,
        OP_DEC  = 4'd2,
        OP_BSET = 4'd3,
        OP_BCLR = 4'd4,
        OP_BTST = 4'd5,
        OP_SHF  = 4'd6,
        OP_ROT  = 4'd7,
        OP_ZERO = 4'd8,
        OP_INV  = 4'd9,
        OP_AND  = 4'd10,
        OP_OR   = 4'd11,
        OP_XOR  = 4'd12
    } lrl_op_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } lrl_flags_t;

    // carry is touched only by counting and bit-moving commands
    function automatic logic op_moves_carry(input logic [OPW-1:0] op);
        return (op == OP_INC) || (op == OP_DEC) || (op == OP_SHF) || (op == OP_ROT);
    endfunction

    // true for every command that yields a new word
    function automatic logic op_has_result(input logic [OPW-1:0] op);
        return (op >= OP_INC && op <= OP_BCLR) || (op >= OP_SHF && op <= OP_XOR);
    endfunction

endpackage

// File: rtl/lrl_op_unit.sv
module lrl_op_unit
    import lrl_pkg::*;
#(
    parameter int W    = 16,
    parameter int IDXW = $clog2(W)
) (
    input  logic [W-1:0]    a,
    input  logic [W-1:0]    b,
    input  logic [OPW-1:0]  op,
    input  logic [IDXW-1:0] idx,
    input  logic            dir_left,
    output logic [W-1:0]    res,
    output lrl_flags_t      flg_new,
    output lrl_flags_t      flg_upd,
    output logic            has_res
);

    logic [W:0]   sum_inc;
    logic [W:0]   sum_dec;
    logic [W-1:0] bit_mask;
    logic         bit_out;

    assign sum_inc  = {1'b0, a} + {{W{1'b0}}, 1'b1};
    assign sum_dec  = {1'b0, a} - {{W{1'b0}}, 1'b1};
    assign bit_mask = {{(W-1){1'b0}}, 1'b1} << idx;
    assign bit_out  = dir_left ? a[W-1] : a[0];
    assign has_res  = op_has_result(op);

    always_comb begin
        res       = a;
        flg_new   = '0;
        flg_upd   = '0;
        case (op)
            OP_INC:  res = sum_inc[W-1:0];
            OP_DEC:  res = sum_dec[W-1:0];
            OP_BSET: res = a | bit_mask;
            OP_BCLR: res = a & ~bit_mask;
            OP_SHF:  res = dir_left ? {a[W-2:0], 1'b0} : {1'b0, a[W-1:1]};
            OP_ROT:  res = dir_left ? {a[W-2:0], a[W-1]} : {a[0], a[W-1:1]};
            OP_ZERO: res = '0;
            OP_INV:  res = ~a;
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            default: res = a;
        endcase

        if (has_res) begin
            flg_new.z = (res == '0);
            flg_new.n = res[W-1];
            flg_upd.z = 1'b1;
            flg_upd.n = 1'b1;
        end

        if (op_moves_carry(op)) begin
            flg_upd.c = 1'b1;
            case (op)
                OP_INC:  flg_new.c = sum_inc[W];
                OP_DEC:  flg_new.c = sum_dec[W];
                default: flg_new.c = bit_out;
            endcase
        end

        if (op == OP_BTST) begin
            flg_new.z = ~|(a & bit_mask);
            flg_upd.z = 1'b1;
        end
    end

endmodule

// File: rtl/lrl_latch_bank.sv
module lrl_latch_bank #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_en,
    input  logic [W-1:0] ld_data,
    input  logic         xfer_en,
    input  logic [W-1:0] xfer_data,
    input  logic         wb_en,
    input  logic [W-1:0] wb_data,
    output logic [W-1:0] a_q,
    output logic [W-1:0] b_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else if (xfer_en) begin
            a_q <= xfer_data;
            b_q <= xfer_data;
        end else if (ld_en) begin
            a_q <= ld_data;
        end else if (wb_en) begin
            a_q <= wb_data;
        end
    end

    // R3
    xfer_both_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_en |=> (a_q == $past(xfer_data)) && (b_q == $past(xfer_data)));

    // R2
    ld_a_only_chk: assert property (@(posedge clk) disable iff (rst)
        (ld_en && !xfer_en) |=> (a_q == $past(ld_data)) && $stable(b_q));

    // R2
    b_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !xfer_en |=> $stable(b_q));

endmodule

// File: rtl/lrl_flag_reg.sv
module lrl_flag_reg
    import lrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  lrl_flags_t upd,
    input  lrl_flags_t nxt,
    output lrl_flags_t q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            if (upd.z) q.z <= nxt.z;
            if (upd.n) q.n <= nxt.n;
            if (upd.c) q.c <= nxt.c;
        end
    end

    // R12
    flags_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

endmodule

// File: rtl/reg_local_unit.sv
module reg_local_unit
    import lrl_pkg::*;
#(
    parameter  int W    = 16,
    localparam int IDXW = $clog2(W)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ld_en,
    input  logic [W-1:0]    ld_data,
    input  logic            xfer_en,
    input  logic [W-1:0]    xfer_data,
    input  logic            op_valid,
    input  logic [OPW-1:0]  op_code,
    input  logic [IDXW-1:0] op_arg,
    input  logic            op_dir,
    input  logic            op_to_bus,
    output logic [W-1:0]    a_out,
    output logic            rbus_valid,
    output logic [W-1:0]    rbus_data,
    output logic            flag_z,
    output logic            flag_n,
    output logic            flag_c
);

    logic [W-1:0] a_q, b_q, res;
    lrl_flags_t   flg_new, flg_upd, flg_q;
    logic         has_res, op_go, wb_en, bus_go;

    assign op_go  = op_valid && !ld_en && !xfer_en;
    assign wb_en  = op_go && has_res && !op_to_bus;
    assign bus_go = op_go && has_res && op_to_bus;

    lrl_op_unit #(.W(W), .IDXW(IDXW)) u_ops (
        .a        (a_q),
        .b        (b_q),
        .op       (op_code),
        .idx      (op_arg),
        .dir_left (op_dir),
        .res      (res),
        .flg_new  (flg_new),
        .flg_upd  (flg_upd),
        .has_res  (has_res)
    );

    lrl_latch_bank #(.W(W)) u_latch (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_data   (ld_data),
        .xfer_en   (xfer_en),
        .xfer_data (xfer_data),
        .wb_en     (wb_en),
        .wb_data   (res),
        .a_q       (a_q),
        .b_q       (b_q)
    );

    lrl_flag_reg u_flags (
        .clk (clk),
        .rst (rst),
        .en  (op_go),
        .upd (flg_upd),
        .nxt (flg_new),
        .q   (flg_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rbus_valid <= 1'b0;
            rbus_data  <= '0;
        end else begin
            rbus_valid <= bus_go;
            rbus_data  <= bus_go ? res : '0;
        end
    end

    assign a_out  = a_q;
    assign flag_z = flg_q.z;
    assign flag_n = flg_q.n;
    assign flag_c = flg_q.c;

    // R6
    btst_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_code == OP_BTST) |=> $stable(a_out) && $stable(flag_n) && $stable(flag_c));

    // R11
    bus_keeps_a_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_to_bus) |=> $stable(a_out));

    // R12
    blocked_no_bus_chk: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (ld_en || xfer_en)) |=> !rbus_valid);

    // R11
    bus_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rbus_valid |=> !rbus_valid || $past(bus_go));

    // R9
    logic_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
        (op_go && op_code >= OP_ZERO) |=> $stable(flag_c));

endmodule

// File: tb/sim_reg_local_unit.sv
module sim_reg_local_unit;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en, xfer_en, op_valid, op_dir, op_to_bus;
    logic [15:0] ld_data, xfer_data;
    logic [3:0]  op_code, op_arg;
    logic [15:0] a_out, rbus_data;
    logic        rbus_valid, flag_z, flag_n, flag_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    reg_local_unit #(.W(16)) u0 (
        .clk(clk), .rst(rst),
        .ld_en(ld_en), .ld_data(ld_data),
        .xfer_en(xfer_en), .xfer_data(xfer_data),
        .op_valid(op_valid), .op_code(op_code), .op_arg(op_arg),
        .op_dir(op_dir), .op_to_bus(op_to_bus),
        .a_out(a_out), .rbus_valid(rbus_valid), .rbus_data(rbus_data),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [2:0] flg();
        return {flag_z, flag_n, flag_c};
    endfunction

    task automatic idle();
        ld_en = 0; xfer_en = 0; op_valid = 0; op_dir = 0; op_to_bus = 0;
        ld_data = '0; xfer_data = '0; op_code = '0; op_arg = '0;
    endtask

    // one cycle: drive at negedge, return just after the capturing edge
    task automatic tick();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic ld(input logic [15:0] v);
        @(negedge clk); ld_en = 1; ld_data = v; tick();
    endtask

    task automatic xf(input logic [15:0] v);
        @(negedge clk); xfer_en = 1; xfer_data = v; tick();
    endtask

    task automatic op(input logic [3:0] c, input logic [3:0] arg, input logic dir, input logic bus);
        @(negedge clk);
        op_valid = 1; op_code = c; op_arg = arg; op_dir = dir; op_to_bus = bus;
        tick();
    endtask

    task automatic t_reset();
        chk("R1 a after reset", a_out, 16'h0);
        chk("R1 flags after reset", flg(), 3'b000);
        chk("R1 bus idle after reset", rbus_valid, 1'b0);
        ld(16'hFFFF);
        op(4'd11, 0, 0, 0);
        chk("R1 B zero (A|B)", a_out, 16'hFFFF);
        ld(16'hFFFF);
        op(4'd10, 0, 0, 0);
        chk("R1 B zero (A&B)", a_out, 16'h0000);
    endtask

    task automatic t_load();
        logic [2:0] f;
        xf(16'h00F0);
        chk("R3 xfer to A", a_out, 16'h00F0);
        f = flg();
        ld(16'h1234);
        chk("R2 load A", a_out, 16'h1234);
        chk("R2 load keeps flags", flg(), f);
        op(4'd11, 0, 0, 0);
        chk("R2 B untouched by load", a_out, 16'h12F4);
    endtask

    task automatic t_xfer_prio();
        @(negedge clk);
        ld_en = 1; ld_data = 16'h1111; xfer_en = 1; xfer_data = 16'h2222;
        tick();
        chk("R3 xfer beats load", a_out, 16'h2222);
        op(4'd12, 0, 0, 0);
        chk("R3 B took xfer value", a_out, 16'h0000);
        chk("R10 zero after xor", flg(), 3'b100);
    endtask

    task automatic t_incdec();
        ld(16'hFFFF); op(4'd1, 0, 0, 0);
        chk("R4 inc wrap", a_out, 16'h0000);
        chk("R4 inc carry", flg(), 3'b101);
        op(4'd1, 0, 0, 0);
        chk("R4 inc plain", {a_out, 13'h0, flg()}, {16'h0001, 13'h0, 3'b000});
        ld(16'h0000); op(4'd2, 0, 0, 0);
        chk("R4 dec borrow", {a_out, 13'h0, flg()}, {16'hFFFF, 13'h0, 3'b011});
        op(4'd2, 0, 0, 0);
        chk("R4 dec plain", {a_out, 13'h0, flg()}, {16'hFFFE, 13'h0, 3'b010});
    endtask

    task automatic t_bits();
        logic [2:0] f;
        ld(16'h0000);
        op(4'd3, 4'd15, 0, 0);
        chk("R5 bset 15", a_out, 16'h8000);
        chk("R10 negative on bit15", flg() & 3'b110, 3'b010);
        op(4'd4, 4'd15, 0, 0);
        chk("R5 bclr 15", a_out, 16'h0000);
        chk("R10 zero after bclr", flg() & 3'b110, 3'b100);
        op(4'd3, 4'd0, 0, 0);
        op(4'd3, 4'd3, 0, 0);
        chk("R5 bset 0 and 3", a_out, 16'h0009);
        ld(16'h8009); op(4'd6, 0, 1, 0); // C=1, N=0
        ld(16'h8009);
        f = flg();
        op(4'd5, 4'd3, 0, 0);
        chk("R6 btst set bit", {a_out, 13'h0, flg()}, {16'h8009, 13'h0, 1'b0, f[1:0]});
        op(4'd5, 4'd4, 0, 0);
        chk("R6 btst clear bit", {a_out, 13'h0, flg()}, {16'h8009, 13'h0, 1'b1, f[1:0]});
    endtask

    task automatic t_shift();
        ld(16'h8001); op(4'd6, 0, 1, 0);
        chk("R7 shl", {a_out, 13'h0, flg()}, {16'h0002, 13'h0, 3'b001});
        op(4'd6, 0, 0, 0);
        chk("R7 shr", {a_out, 13'h0, flg()}, {16'h0001, 13'h0, 3'b000});
        op(4'd6, 0, 0, 0);
        chk("R7 shr out", {a_out, 13'h0, flg()}, {16'h0000, 13'h0, 3'b101});
    endtask

    task automatic t_rot();
        ld(16'h8001); op(4'd7, 0, 1, 0);
        chk("R8 rol", {a_out, 13'h0, flg()}, {16'h0003, 13'h0, 3'b001});
        op(4'd7, 0, 0, 0);
        chk("R8 ror", {a_out, 13'h0, flg()}, {16'h8001, 13'h0, 3'b011});
        op(4'd7, 0, 0, 0);
        chk("R8 ror again", {a_out, 13'h0, flg()}, {16'hC000, 13'h0, 3'b011});
    endtask

    task automatic t_logic();
        xf(16'h0F0F);
        ld(16'h8000); op(4'd6, 0, 1, 0); // carry set to 1
        ld(16'h00FF); op(4'd10, 0, 0, 0);
        chk("R9 and", {a_out, 13'h0, flg()}, {16'h000F, 13'h0, 3'b001});
        ld(16'h00FF); op(4'd11, 0, 0, 0);
        chk("R9 or", a_out, 16'h0FFF);
        ld(16'h00FF); op(4'd12, 0, 0, 0);
        chk("R9 xor", a_out, 16'h0FF0);
        op(4'd9, 0, 0, 0);
        chk("R9 inv", {a_out, 13'h0, flg()}, {16'hF00F, 13'h0, 3'b011});
        op(4'd8, 0, 0, 0);
        chk("R9 zero keeps carry", {a_out, 13'h0, flg()}, {16'h0000, 13'h0, 3'b101});
    endtask

    task automatic t_bus();
        ld(16'h7FFF);
        op(4'd1, 0, 0, 1);
        chk("R11 bus valid", rbus_valid, 1'b1);
        chk("R11 bus data", rbus_data, 16'h8000);
        chk("R11 A kept", a_out, 16'h7FFF);
        chk("R11 flags from result", flg(), 3'b010);
        @(posedge clk); #1;
        chk("R11 single pulse", {rbus_valid, rbus_data}, {1'b0, 16'h0});
    endtask

    task automatic t_block();
        logic [2:0] f;
        ld(16'h0000);
        f = flg();
        @(negedge clk);
        ld_en = 1; ld_data = 16'h0005; op_valid = 1; op_code = 4'd1; op_to_bus = 1;
        tick();
        chk("R12 load wins", a_out, 16'h0005);
        chk("R12 no bus on collision", rbus_valid, 1'b0);
        chk("R12 flags kept", flg(), f);
        @(negedge clk);
        xfer_en = 1; xfer_data = 16'h00FF; op_valid = 1; op_code = 4'd9;
        tick();
        chk("R12 xfer wins over op", {a_out, 13'h0, flg()}, {16'h00FF, 13'h0, f});
    endtask

    task automatic t_nop();
        logic [2:0] f;
        ld(16'h8000); op(4'd6, 0, 1, 0); // A=0, Z=1 N=0 C=1
        ld(16'h5A5A);
        f = flg();
        for (int c = 0; c < 16; c++) begin
            if (c == 0 || c >= 13) begin
                op(c[3:0], 4'd2, 1, 0);
                chk("R13 unused code", {a_out, 13'h0, flg()}, {16'h5A5A, 13'h0, f});
                chk("R13 unused code no bus", rbus_valid, 1'b0);
            end
        end
    endtask

    initial begin
        idle();
        rst = 1;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        t_reset();
        t_load();
        t_xfer_prio();
        t_incdec();
        t_bits();
        t_shift();
        t_rot();
        t_logic();
        t_bus();
        t_block();
        t_nop();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule